// File: doc/BRIEF.md
# Bounded-Retry Bus Transaction Manager

This block sits on the master side of a management bus, between a host command port and a byte-transaction engine. It takes one command at a time, which is either a read or a configuration write. It hands each command to the engine and watches the result. Failures are a negative acknowledge or no completion within a timeout. A failed attempt is reissued after a backoff that doubles on each retry, up to a fixed retry cap. A stuck-low bus line indication ends the command at once and raises a hang flag, with no retry.

Every configuration write is followed by a read of the same address. The write counts as good only when the value read back matches. While the fault window input is high, writes are refused without touching the bus. Failed attempts are also counted in a saturating counter that is cleared at the end of each fixed-length observation window. This keeps recovery bounded, so bus trouble cannot grow into a storm of repeated traffic near the power rail.

Top module: `txn_retry_mgr`

## Requirements
- R1: A command accepted on an edge (`cmd_valid` high while `cmd_ready` is high) drives `eng_start` high for exactly one cycle, in the cycle after acceptance. A read the engine acknowledges completes with `rsp_valid` pulsed for one cycle, `rsp_status` = 2'b00 and the read value on `rsp_rdata`.
- R2: An engine completion with `eng_ack` low, or no completion within `TIMEOUT` cycles of waiting, is a failed attempt. A command is retried at most `MAX_RETRY` times. When the last attempt fails, it completes with `rsp_status` = 2'b01.
- R3: Before retry k (k = 1, 2, ...), the block idles for `BACKOFF_BASE << (k-1)` cycles. The distance between consecutive `eng_start` pulses is the engine latency plus the backoff plus one cycle. For a timeout, the timeout length takes the place of the engine latency.
- R4: A write accepted while `fault_win` is high completes in the next cycle with `rsp_status` = 2'b10 and no `eng_start`. Reads are not affected by `fault_win`.
- R5: A write is followed by a read of the same address, with `eng_write` low. The result is status 2'b00 when the read value equals the written data. It is 2'b11 on a mismatch, with no retry.
- R6: `eng_stuck` going high while an attempt is waiting ends the command in the next cycle with status 2'b01, sets `bus_hang` and issues no retry. `bus_hang` is cleared when the next command is accepted.
- R7: `err_cnt` increases by one for each failed attempt (negative acknowledge, timeout or stuck line) and holds at its maximum, 2^`ERR_W`-1.
- R8: `err_cnt` is cleared on every `WIN_LEN`-th clock edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Block idle, command will be accepted |
| cmd_write | input | 1 | 1 = configuration write, 0 = read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Write data |
| fault_win | input | 1 | Fault window active, writes refused |
| eng_start | output | 1 | One-cycle request to the transaction engine |
| eng_write | output | 1 | Engine request is a write |
| eng_addr | output | ADDR_W | Engine request address |
| eng_wdata | output | DATA_W | Engine write data |
| eng_done | input | 1 | Engine transaction finished |
| eng_ack | input | 1 | Finished transaction was acknowledged |
| eng_rdata | input | DATA_W | Engine read data |
| eng_stuck | input | 1 | Bus line held low |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 retries exhausted or hang, 10 blocked, 11 read-back mismatch |
| rsp_rdata | output | DATA_W | Read or read-back value |
| bus_hang | output | 1 | Last command ended on a stuck line |
| err_cnt | output | ERR_W | Failed attempts in the current window |

## Verification
The engine start is due one cycle after acceptance. A response is due one cycle after the final engine completion, after the last timed-out wait cycle, or after a stuck indication. A refused write answers in the cycle right after acceptance. The bench counts clock edges from reset release. It records the edge count of every start and of every response, and compares the gaps with the latency + backoff + 1 formula. It samples on falling edges only. Error-count scenarios begin right after a window boundary, so the expected count is not disturbed by a clear.

// File: rtl/txn_retry_mgr.sv
module txn_retry_mgr #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int MAX_RETRY    = 3,
  parameter int BACKOFF_BASE = 4,
  parameter int TIMEOUT      = 16,
  parameter int WIN_LEN      = 1024,
  parameter int ERR_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              fault_win,
  output logic              eng_start,
  output logic              eng_write,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              eng_stuck,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_hang,
  output logic [ERR_W-1:0]  err_cnt
);
  localparam int RT_W = $clog2(MAX_RETRY + 1) + 1;
  localparam int BK_W = $clog2(BACKOFF_BASE << MAX_RETRY) + 1;
  localparam int TO_W = $clog2(TIMEOUT) + 1;
  localparam int WN_W = $clog2(WIN_LEN) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_BACK} st_t;

  st_t              st;
  logic             is_wr, rd_phase;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [RT_W-1:0]  tries;
  logic [BK_W-1:0]  bk;
  logic [TO_W-1:0]  tmr;
  logic [WN_W-1:0]  wcnt;

  logic accept, hang_ev, fail_ev, err_ev, win_end;

  assign cmd_ready = (st == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign eng_start = (st == S_ISSUE);
  assign eng_write = is_wr && !rd_phase;
  assign eng_addr  = addr;
  assign eng_wdata = wdata;
  assign hang_ev   = (st == S_WAIT) && eng_stuck;
  assign fail_ev   = (st == S_WAIT) && !eng_stuck &&
                     ((eng_done && !eng_ack) || (!eng_done && tmr == TO_W'(TIMEOUT - 1)));
  assign err_ev    = hang_ev || fail_ev;
  assign win_end   = (wcnt == WN_W'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; is_wr <= 1'b0; rd_phase <= 1'b0;
      addr <= '0; wdata <= '0; tries <= '0; bk <= '0; tmr <= '0;
      rsp_valid <= 1'b0; rsp_status <= 2'b00; rsp_rdata <= '0; bus_hang <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          bus_hang <= 1'b0;
          is_wr    <= cmd_write;
          addr     <= cmd_addr;
          wdata    <= cmd_wdata;
          tries    <= '0;
          rd_phase <= !cmd_write;
          if (cmd_write && fault_win) begin
            rsp_valid  <= 1'b1;
            rsp_status <= 2'b10;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          st  <= S_WAIT;
          tmr <= '0;
        end
        S_WAIT: begin
          tmr <= tmr + 1'b1;
          if (hang_ev) begin
            bus_hang   <= 1'b1;
            rsp_valid  <= 1'b1;
            rsp_status <= 2'b01;
            st         <= S_IDLE;
          end else if (fail_ev) begin
            if (tries == RT_W'(MAX_RETRY)) begin
              rsp_valid  <= 1'b1;
              rsp_status <= 2'b01;
              st         <= S_IDLE;
            end else begin
              tries    <= tries + 1'b1;
              bk       <= BK_W'(BACKOFF_BASE) << tries;
              rd_phase <= !is_wr;
              st       <= S_BACK;
            end
          end else if (eng_done) begin
            if (!rd_phase) begin
              rd_phase <= 1'b1;
              st       <= S_ISSUE;
            end else begin
              rsp_rdata  <= eng_rdata;
              rsp_valid  <= 1'b1;
              rsp_status <= (is_wr && eng_rdata != wdata) ? 2'b11 : 2'b00;
              st         <= S_IDLE;
            end
          end
        end
        S_BACK: begin
          if (bk == BK_W'(1)) st <= S_ISSUE;
          else                bk <= bk - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= '0;
      err_cnt <= '0;
    end else begin
      wcnt <= win_end ? '0 : wcnt + 1'b1;
      if (win_end)                       err_cnt <= {{(ERR_W-1){1'b0}}, err_ev};
      else if (err_ev && err_cnt != '1)  err_cnt <= err_cnt + 1'b1;
    end
  end

  p_one_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_retry_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= RT_W'(MAX_RETRY));
  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_write && fault_win) |=> (rsp_valid && rsp_status == 2'b10 && !eng_start));
  p_hang_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && eng_stuck) |=> (rsp_valid && bus_hang && rsp_status == 2'b01 && cmd_ready));
  p_err_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == '1 && !win_end) |=> (err_cnt == '1));
  p_win_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !err_ev) |=> (err_cnt == '0));
endmodule

// File: tb/txn_retry_mgr_tb.sv
module txn_retry_mgr_tb_top;
  localparam int AW = 8, DW = 8, MR = 3, BB = 4, TO = 16, WIN = 1024, EW = 3, LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, fault_win = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic eng_done = 0, eng_ack = 0, eng_stuck = 0;
  logic [DW-1:0] eng_rdata = '0;
  logic cmd_ready, eng_start, eng_write, rsp_valid, bus_hang;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_wdata, rsp_rdata;
  logic [1:0] rsp_status;
  logic [EW-1:0] err_cnt;

  always #2 clk = ~clk;

  txn_retry_mgr #(.ADDR_W(AW), .DATA_W(DW), .MAX_RETRY(MR), .BACKOFF_BASE(BB),
    .TIMEOUT(TO), .WIN_LEN(WIN), .ERR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .fault_win(fault_win), .eng_start(eng_start), .eng_write(eng_write),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_stuck(eng_stuck),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .bus_hang(bus_hang), .err_cnt(err_cnt));

  int total = 0, bad = 0, cyc = 0;
  int starts = 0, pidx = 0, dly = 0, mode = 0;
  int st_cyc [0:15];
  int plan [0:15];
  bit busy = 0, corrupt = 0;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] mem [0:255];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    eng_done = 0;
    if (busy) begin
      if (dly == 1) begin
        busy = 0;
        case (mode)
          0: begin eng_done = 1; eng_ack = 1; eng_rdata = mem[cur_addr] ^ (corrupt ? 8'h01 : 8'h00); end
          1: begin eng_done = 1; eng_ack = 0; end
          3: eng_stuck = 1;
          default: ;
        endcase
      end else dly--;
    end
    if (eng_start) begin
      if (starts < 16) st_cyc[starts] = cyc;
      starts++;
      mode = plan[pidx % 16]; pidx++;
      busy = 1; dly = LAT; cur_addr = eng_addr;
      if (eng_write && mode == 0) mem[eng_addr] = eng_wdata;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic set_plan(input int a, input int b, input int c, input int d);
    plan[0] = a; plan[1] = b; plan[2] = c; plan[3] = d;
    for (int i = 4; i < 16; i++) plan[i] = 0;
    pidx = 0; starts = 0;
  endtask

  int acc_c, rsp_c;
  logic [1:0] got_st;
  logic [DW-1:0] got_rd;

  task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; acc_c = cyc;
    @(negedge clk);
    cmd_valid = 0;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    chk("R1 response arrives", rsp_valid, n, 2000);
    rsp_c = cyc; got_st = rsp_status; got_rd = rsp_rdata;
  endtask

  task automatic align_win();
    @(negedge clk);
    while (cyc % WIN != 1) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", cmd_ready === 1'b1, cmd_ready, 1);
    chk("R1 reset no rsp", rsp_valid === 1'b0 && eng_start === 1'b0, rsp_valid, 0);
    chk("R7 reset err_cnt", err_cnt === 0, err_cnt, 0);
    chk("R6 reset bus_hang", bus_hang === 1'b0, bus_hang, 0);
  endtask

  task automatic t_read_ok();
    set_plan(0, 0, 0, 0);
    mem[8'h10] = 8'h3C;
    do_cmd(0, 8'h10, 8'h00);
    chk("R1 read status", got_st == 2'b00, got_st, 0);
    chk("R1 read data", got_rd == 8'h3C, got_rd, 8'h3C);
    chk("R1 one start", starts == 1, starts, 1);
    chk("R1 start cycle", st_cyc[0] == acc_c + 1, st_cyc[0], acc_c + 1);
    chk("R1 rsp cycle", rsp_c == st_cyc[0] + LAT + 1, rsp_c, st_cyc[0] + LAT + 1);
  endtask

  task automatic t_write_ok();
    set_plan(0, 0, 0, 0); corrupt = 0;
    do_cmd(1, 8'h22, 8'h5A);
    chk("R5 write status", got_st == 2'b00, got_st, 0);
    chk("R5 readback value", got_rd == 8'h5A, got_rd, 8'h5A);
    chk("R5 write+read starts", starts == 2, starts, 2);
    chk("R5 readback gap", st_cyc[1] - st_cyc[0] == LAT + 1, st_cyc[1] - st_cyc[0], LAT + 1);
    chk("R5 memory written", mem[8'h22] == 8'h5A, mem[8'h22], 8'h5A);
  endtask

  task automatic t_mismatch();
    set_plan(0, 0, 0, 0); corrupt = 1;
    do_cmd(1, 8'h23, 8'h77);
    corrupt = 0;
    chk("R5 mismatch status", got_st == 2'b11, got_st, 3);
    chk("R5 mismatch no retry", starts == 2, starts, 2);
  endtask

  task automatic t_nack_retry();
    set_plan(1, 1, 0, 0);
    mem[8'h30] = 8'h99;
    do_cmd(0, 8'h30, 8'h00);
    chk("R2 recovered status", got_st == 2'b00 && got_rd == 8'h99, got_st, 0);
    chk("R2 attempt count", starts == 3, starts, 3);
    chk("R3 backoff 1", st_cyc[1] - st_cyc[0] == LAT + BB + 1, st_cyc[1] - st_cyc[0], LAT + BB + 1);
    chk("R3 backoff 2", st_cyc[2] - st_cyc[1] == LAT + 2*BB + 1, st_cyc[2] - st_cyc[1], LAT + 2*BB + 1);
  endtask

  task automatic t_exhaust();
    align_win();
    chk("R8 cleared after boundary", err_cnt == 0, err_cnt, 0);
    set_plan(2, 2, 2, 2);
    do_cmd(0, 8'h40, 8'h00);
    chk("R2 exhausted status", got_st == 2'b01, got_st, 1);
    chk("R2 retry cap", starts == MR + 1, starts, MR + 1);
    chk("R3 timeout gap 1", st_cyc[1] - st_cyc[0] == TO + BB + 1, st_cyc[1] - st_cyc[0], TO + BB + 1);
    chk("R3 timeout gap 2", st_cyc[2] - st_cyc[1] == TO + 2*BB + 1, st_cyc[2] - st_cyc[1], TO + 2*BB + 1);
    chk("R3 timeout gap 3", st_cyc[3] - st_cyc[2] == TO + 4*BB + 1, st_cyc[3] - st_cyc[2], TO + 4*BB + 1);
    chk("R2 final rsp cycle", rsp_c == st_cyc[3] + TO + 1, rsp_c, st_cyc[3] + TO + 1);
    chk("R7 timeouts counted", err_cnt == 4, err_cnt, 4);
  endtask

  task automatic t_block();
    set_plan(0, 0, 0, 0);
    mem[8'h50] = 8'h11;
    fault_win = 1;
    do_cmd(1, 8'h50, 8'hEE);
    chk("R4 blocked status", got_st == 2'b10, got_st, 2);
    chk("R4 blocked timing", rsp_c == acc_c + 1, rsp_c, acc_c + 1);
    chk("R4 no engine start", starts == 0, starts, 0);
    chk("R4 memory untouched", mem[8'h50] == 8'h11, mem[8'h50], 8'h11);
    do_cmd(0, 8'h50, 8'h00);
    fault_win = 0;
    chk("R4 read allowed", got_st == 2'b00 && got_rd == 8'h11, got_st, 0);
  endtask

  task automatic t_stuck();
    int e0;
    align_win();
    e0 = err_cnt;
    set_plan(3, 0, 0, 0);
    do_cmd(0, 8'h60, 8'h00);
    chk("R6 stuck status", got_st == 2'b01, got_st, 1);
    chk("R6 bus_hang set", bus_hang == 1'b1, bus_hang, 1);
    chk("R6 no retry", starts == 1, starts, 1);
    chk("R6 abort cycle", rsp_c == st_cyc[0] + LAT + 1, rsp_c, st_cyc[0] + LAT + 1);
    chk("R7 stuck counted", err_cnt == e0 + 1, err_cnt, e0 + 1);
    eng_stuck = 0;
    set_plan(0, 0, 0, 0);
    do_cmd(0, 8'h10, 8'h00);
    chk("R6 bus_hang cleared", bus_hang == 1'b0 && got_st == 2'b00, bus_hang, 0);
  endtask

  task automatic t_saturate();
    align_win();
    set_plan(1, 1, 1, 1);
    do_cmd(0, 8'h70, 8'h00);
    chk("R7 count four", err_cnt == 4, err_cnt, 4);
    set_plan(1, 1, 1, 1);
    do_cmd(0, 8'h71, 8'h00);
    chk("R7 saturated", err_cnt == 7, err_cnt, 7);
    while (cyc % WIN != WIN - 1) @(negedge clk);
    chk("R8 held before boundary", err_cnt == 7, err_cnt, 7);
    @(negedge clk);
    chk("R8 cleared at boundary", err_cnt == 0, err_cnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) begin plan[i] = 0; st_cyc[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_write_ok();
    t_mismatch();
    t_nack_retry();
    t_exhaust();
    t_block();
    t_stuck();
    t_saturate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule